// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a byte-wide parallel flash. It takes one request that names either a byte program or a whole-array erase. It plays the unlock-and-command write sequence onto the flash strobe bus, then reads the target location back until the internal operation reports that it has finished. Two judging methods are available, chosen per request. The first compares bit 7 of each status read with bit 7 of the expected final byte. The second watches bit 6 and waits for it to stop toggling between reads.

The end of the flash's internal operation is not tied to the host clock, so a status read can straddle it and return a byte that is half status and half data. For that reason an apparent completion is never taken at face value. The block always issues two more reads of the same location and reports success only if both return exactly the expected byte. A limit on the number of status reads turns a stuck operation into an error. Setup, strobe width and hold of every bus cycle are whole clock cycles set by parameters.

Requests arrive on a valid/ready port. The source holds `req_erase`, `req_toggle`, `req_addr` and `req_data` stable while `req_valid` is high and `req_ready` is low. A request transfers in a cycle where both are high. `req_ready` is high only while the poller is idle, so back-pressure lasts for the whole operation and nothing is buffered. Completion is signalled by a single-cycle `done` or `error` pulse, in the same cycle that `req_ready` rises again.

Top module: `fwc_poller`

## Requirements
- R1: While reset is held and after it, with no request, `req_ready` is 1, `fl_sel_n`, `fl_rd_n` and `fl_wr_n` are 1, and `fl_dq_oe`, `done` and `error` are 0.
- R2: A request is taken in a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 from the next cycle until the cycle in which `done` or `error` pulses, and `req_valid` has no effect while it is 0.
- R3: A program request (`req_erase`=0) issues exactly four writes, given as address/data: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then `req_addr`/`req_data`. An erase request (`req_erase`=1) issues exactly six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h.
- R4: In every bus cycle, `fl_sel_n` is low for SETUP_CYC+PULSE_CYC+HOLD_CYC clocks. The strobe (`fl_wr_n` for a write, `fl_rd_n` for a read) is low for exactly PULSE_CYC clocks after SETUP_CYC clocks. `fl_dq_oe` is 1 only inside write cycles, and never while `fl_rd_n` is low or `fl_sel_n` is high.
- R5: At most one of `fl_sel_n`, `fl_rd_n` and `fl_wr_n` changes per clock. `fl_rd_n` and `fl_wr_n` are never low together, and a strobe is low only while `fl_sel_n` is low.
- R6: Reads happen only after the last command write and only at `req_addr`. No write is issued once reading has begun.
- R7: With `req_toggle`=0, a status read counts as complete when its bit 7 equals bit 7 of the expected byte. The expected byte is `req_data` for a program and FFh for an erase.
- R8: With `req_toggle`=1, a status read counts as complete when its bit 6 equals bit 6 of the previous status read of the same request. The first status read never counts as complete.
- R9: After a complete-looking status read, exactly two more reads are issued. `done` pulses if both equal the expected byte in all eight bits, and `error` pulses otherwise. The status read itself need only satisfy R7 or R8.
- R10: If TIMEOUT_POLLS status reads in a row do not look complete, `error` pulses after the last of them and no further read is issued.
- R11: Each accepted request yields exactly one single-cycle pulse on `done` or on `error`, never both. With N bus cycles in the request, the pulse is visible in the cycle that follows clock edge N*(SETUP_CYC+PULSE_CYC+HOLD_CYC+2), counting the accepting edge as edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Poller idle, request can transfer |
| req_erase | input | 1 | 1 = whole-array erase, 0 = byte program |
| req_toggle | input | 1 | 1 = bit-6 toggle judging, 0 = bit-7 match judging |
| req_addr | input | ADDR_W | Target byte address, also the polled location |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle pulse: operation confirmed |
| error | output | 1 | One-cycle pulse: confirmation failed or timeout |
| fl_sel_n | output | 1 | Flash select, active low |
| fl_rd_n | output | 1 | Flash read strobe, active low |
| fl_wr_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8 | Write data toward the flash |
| fl_dq_oe | output | 1 | Enable for the write data driver |
| fl_dq_i | input | 8 | Read data from the flash |

## Verification
The two events that can land in the same bus cycle are the end of the flash's internal operation and a status read. The bench's flash model provokes this by returning a mixed byte on the first read after its busy count expires. In that byte the judged bits 7 and 6 already hold their final values, but the low bits are still wrong. The mixed read must be accepted as a completion without failing the request, and only the two following full-byte reads decide between `done` and `error`. The sweep places this read after every busy length from zero to five, under both judging methods and both operations, with and without a corrupted final byte. For each case the bench computes the number of reads and the latency.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } bus_ph_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CMD_WAIT,
    ST_POLL,
    ST_POLL_WAIT,
    ST_CONF,
    ST_CONF_WAIT
  } ctl_st_t;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
  } unlock_t;

  // Command write for a given step; the final program step is replaced by
  // the target address/data in the controller.
  function automatic unlock_t unlock_step(input logic erase, input logic [2:0] idx);
    unlock_t u;
    case (idx)
      3'd0:    u = '{addr: 16'h5555, data: 8'hAA};
      3'd1:    u = '{addr: 16'h2AAA, data: 8'h55};
      3'd2:    u = '{addr: 16'h5555, data: (erase ? 8'h80 : 8'hA0)};
      3'd3:    u = '{addr: 16'h5555, data: 8'hAA};
      3'd4:    u = '{addr: 16'h2AAA, data: 8'h55};
      default: u = '{addr: 16'h5555, data: 8'h10};
    endcase
    return u;
  endfunction

endpackage

// File: rtl/fwc_bus_cycle.sv
module fwc_bus_cycle
  import fwc_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        wdata,
  output logic              finish,
  output logic [7:0]        rdata,
  output logic              sel_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  input  logic [7:0]        dq_i
);
  localparam int MAX_SP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C  = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  bus_ph_t    ph;
  logic [CNT_W-1:0] cnt;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      addr_out <= '0;
      dq_o     <= '0;
      rdata    <= '0;
      finish   <= 1'b0;
    end else begin
      finish <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          ph       <= PH_SETUP;
          cnt      <= CNT_W'(SETUP_CYC - 1);
          wr_q     <= is_write;
          addr_out <= addr_in;
          dq_o     <= wdata;
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_PULSE;
          cnt <= CNT_W'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin
          ph  <= PH_HOLD;
          cnt <= CNT_W'(HOLD_CYC - 1);
          if (!wr_q) rdata <= dq_i;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          ph     <= PH_IDLE;
          finish <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign sel_n = (ph == PH_IDLE);
  assign wr_n  = !((ph == PH_PULSE) && wr_q);
  assign rd_n  = !((ph == PH_PULSE) && !wr_q);
  assign dq_oe = wr_q && (ph != PH_IDLE);

endmodule

// File: rtl/fwc_status_judge.sv
module fwc_status_judge (
  input  logic       toggle_mode,
  input  logic [7:0] rd_byte,
  input  logic [7:0] expect_byte,
  input  logic       prev_valid,
  input  logic       prev_b6,
  output logic       settled,
  output logic       exact
);
  always_comb begin
    if (toggle_mode) settled = prev_valid && (rd_byte[6] == prev_b6);
    else             settled = (rd_byte[7] == expect_byte[7]);
    exact = (rd_byte == expect_byte);
  end
endmodule

// File: rtl/fwc_poller.sv
module fwc_poller
  import fwc_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int SETUP_CYC     = 1,
  parameter int PULSE_CYC     = 2,
  parameter int HOLD_CYC      = 1,
  parameter int TIMEOUT_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic              req_toggle,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              done,
  output logic              error,
  output logic              fl_sel_n,
  output logic              fl_rd_n,
  output logic              fl_wr_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_i
);
  localparam int POLL_W = $clog2(TIMEOUT_POLLS + 1);

  ctl_st_t           state;
  logic              erase_q, tog_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [2:0]        step;
  logic [POLL_W-1:0] polls;
  logic              conf_idx, conf_bad;
  logic              prev_ok, prev_b6;

  logic              bus_start, bus_wr, bus_fin;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata, expect_byte;
  logic [2:0]        last_step;
  logic              target_step, settled, exact;
  unlock_t           u;

  assign req_ready   = (state == ST_IDLE);
  assign expect_byte = erase_q ? 8'hFF : data_q;
  assign last_step   = erase_q ? 3'd5 : 3'd3;
  assign u           = unlock_step(erase_q, step);
  assign target_step = !erase_q && (step == last_step);
  assign bus_start   = (state == ST_CMD) || (state == ST_POLL) || (state == ST_CONF);
  assign bus_wr      = (state == ST_CMD);
  assign bus_addr    = (bus_wr && !target_step) ? ADDR_W'(u.addr) : addr_q;
  assign bus_wdata   = target_step ? data_q : u.data;

  fwc_bus_cycle #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .start(bus_start), .is_write(bus_wr),
    .addr_in(bus_addr), .wdata(bus_wdata), .finish(bus_fin), .rdata(bus_rdata),
    .sel_n(fl_sel_n), .rd_n(fl_rd_n), .wr_n(fl_wr_n), .addr_out(fl_addr),
    .dq_o(fl_dq_o), .dq_oe(fl_dq_oe), .dq_i(fl_dq_i)
  );

  fwc_status_judge u_judge (
    .toggle_mode(tog_q), .rd_byte(bus_rdata), .expect_byte(expect_byte),
    .prev_valid(prev_ok), .prev_b6(prev_b6), .settled(settled), .exact(exact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      erase_q  <= 1'b0;
      tog_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      step     <= '0;
      polls    <= '0;
      conf_idx <= 1'b0;
      conf_bad <= 1'b0;
      prev_ok  <= 1'b0;
      prev_b6  <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          erase_q <= req_erase;
          tog_q   <= req_toggle;
          addr_q  <= req_addr;
          data_q  <= req_data;
          step    <= '0;
          state   <= ST_CMD;
        end
        ST_CMD: state <= ST_CMD_WAIT;
        ST_CMD_WAIT: if (bus_fin) begin
          if (step == last_step) begin
            polls   <= '0;
            prev_ok <= 1'b0;
            state   <= ST_POLL;
          end else begin
            step  <= step + 1'b1;
            state <= ST_CMD;
          end
        end
        ST_POLL: state <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (bus_fin) begin
          prev_b6 <= bus_rdata[6];
          prev_ok <= 1'b1;
          if (settled) begin
            conf_idx <= 1'b0;
            conf_bad <= 1'b0;
            state    <= ST_CONF;
          end else if (polls == POLL_W'(TIMEOUT_POLLS - 1)) begin
            error <= 1'b1;
            state <= ST_IDLE;
          end else begin
            polls <= polls + 1'b1;
            state <= ST_POLL;
          end
        end
        ST_CONF: state <= ST_CONF_WAIT;
        ST_CONF_WAIT: if (bus_fin) begin
          if (conf_idx) begin
            done  <= exact && !conf_bad;
            error <= !exact || conf_bad;
            state <= ST_IDLE;
          end else begin
            conf_idx <= 1'b1;
            conf_bad <= !exact;
            state    <= ST_CONF;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fwc_poller_chk.sv
module fwc_poller_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic error,
  input logic fl_sel_n,
  input logic fl_rd_n,
  input logic fl_wr_n,
  input logic fl_dq_oe
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fl_rd_n && !fl_wr_n));

  // R5
  strobe_in_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_rd_n || !fl_wr_n) |-> !fl_sel_n);

  // R5
  one_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({fl_sel_n != $past(fl_sel_n), fl_rd_n != $past(fl_rd_n),
                fl_wr_n != $past(fl_wr_n)}) <= 1);

  // R4
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> (fl_rd_n && !fl_sel_n));

  // R11
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  // R11
  outcome_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || error) |=> !(done || error));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  ready_with_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> (done || error));
endmodule

bind fwc_poller fwc_poller_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .error(error), .fl_sel_n(fl_sel_n), .fl_rd_n(fl_rd_n),
  .fl_wr_n(fl_wr_n), .fl_dq_oe(fl_dq_oe)
);

// File: tb/fwc_poller_test.sv
module fwc_poller_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int SC = 1, PC = 2, HC = 1, TO = 8;
  localparam int BUS_LAT = SC + PC + HC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, done, error;
  logic fl_sel_n, fl_rd_n, fl_wr_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_o;
  logic [7:0] fl_dq_i = 8'h00;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwc_poller #(.ADDR_W(AW), .SETUP_CYC(SC), .PULSE_CYC(PC), .HOLD_CYC(HC),
               .TIMEOUT_POLLS(TO)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
    .req_data(req_data), .done(done), .error(error), .fl_sel_n(fl_sel_n),
    .fl_rd_n(fl_rd_n), .fl_wr_n(fl_wr_n), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  // flash model state
  bit run_on = 0;
  int wr_cnt, rd_cnt, busy_n, n_cmd, rd_wrong, sel_low, rd_low, wr_low;
  bit race_f, bad_f;
  logic [7:0] m_exp;
  logic [AW-1:0] m_addr;
  logic [AW-1:0] wa [8];
  logic [7:0] wd [8];

  function automatic logic [7:0] model_val(int k);
    logic [7:0] base;
    if (k <= busy_n) return {~m_exp[7], k[0], 6'h15};
    base = bad_f ? (m_exp ^ 8'h01) : m_exp;
    if (race_f && k == busy_n + 1) return {base[7:6], base[5:0] ^ 6'h3F};
    return base;
  endfunction

  always @(posedge fl_wr_n) if (run_on) begin
    if (wr_cnt < 8) begin wa[wr_cnt] = fl_addr; wd[wr_cnt] = fl_dq_o; end
    wr_cnt++;
  end

  always @(negedge fl_rd_n) if (run_on) begin
    rd_cnt++;
    if (fl_addr != m_addr || wr_cnt != n_cmd) rd_wrong++;
    fl_dq_i = model_val(rd_cnt);
  end

  always @(negedge clk) if (run_on) begin
    sel_low += (fl_sel_n == 1'b0) ? 1 : 0;
    rd_low  += (fl_rd_n == 1'b0) ? 1 : 0;
    wr_low  += (fl_wr_n == 1'b0) ? 1 : 0;
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] seq_step(bit erase, int i, logic [7:0] d, logic [15:0] a);
    case (i)
      0: return {16'h5555, 8'hAA};
      1: return {16'h2AAA, 8'h55};
      2: return erase ? {16'h5555, 8'h80} : {16'h5555, 8'hA0};
      3: return erase ? {16'h5555, 8'hAA} : {a, d};
      4: return {16'h2AAA, 8'h55};
      default: return {16'h5555, 8'h10};
    endcase
  endfunction

  task automatic run_one(bit erase, bit tog, int busy, bit race, bit bad, bit tmo);
    logic [7:0] d;
    logic [AW-1:0] a;
    int c, reads, nbus, cyc, got_done, got_err, exp_done;
    string rtag;
    d = 8'h5A ^ 8'(busy * 8'h47) ^ {tog, 1'b0, race, 5'h0};
    a = AW'(19'h1234 + busy * 19'h0111 + (erase ? 19'h40000 : 0));
    m_exp = erase ? 8'hFF : d;
    m_addr = a; busy_n = tmo ? 100000 : busy; race_f = race; bad_f = bad;
    n_cmd = erase ? 6 : 4;
    if (tmo) c = 0;
    else if (!tog) c = busy + 1;
    else if (busy == 0) c = 2;
    else c = (m_exp[6] == busy[0]) ? busy + 1 : busy + 2;
    reads = tmo ? TO : c + 2;
    nbus = n_cmd + reads;
    exp_done = (!tmo && !bad) ? 1 : 0;
    rtag = tmo ? "R10" : (bad ? "R9" : (tog ? "R8" : "R7"));
    wr_cnt = 0; rd_cnt = 0; rd_wrong = 0; sel_low = 0; rd_low = 0; wr_low = 0;
    run_on = 1;
    @(negedge clk);
    chk("R2 ready before request", int'(req_ready), 1);
    req_valid = 1; req_erase = erase; req_toggle = tog; req_addr = a; req_data = d;
    @(posedge clk);
    // keep offering a different request while busy; it must be ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_data = ~d; req_addr = ~a; req_erase = ~erase;
    end
    req_valid = 0;
    cyc = 3; got_done = 0; got_err = 0;
    while (cyc < 3000 && !(got_done || got_err)) begin
      @(negedge clk); cyc++;
      got_done = int'(done); got_err = int'(error);
    end
    chk("R11 outcome latency", cyc, nbus * BUS_LAT + 1);
    chk({rtag, " done"}, got_done, exp_done);
    chk({rtag, " error"}, got_err, 1 - exp_done);
    chk("R2 ready with outcome", int'(req_ready), 1);
    chk({rtag, " read count"}, rd_cnt, reads);
    chk("R3 write count", wr_cnt, n_cmd);
    for (int i = 0; i < n_cmd && i < 8; i++)
      chk("R3 write addr/data", int'({wa[i][15:0], wd[i]}), int'(seq_step(erase, i, d, a[15:0])));
    chk("R6 read placement", rd_wrong, 0);
    chk("R4 select low clocks", sel_low, nbus * (SC + PC + HC));
    chk("R4 read strobe clocks", rd_low, reads * PC);
    chk("R4 write strobe clocks", wr_low, n_cmd * PC);
    @(negedge clk);
    chk("R11 single pulse", int'(done | error), 0);
    run_on = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R1 strobes in reset", int'({fl_sel_n, fl_rd_n, fl_wr_n}), 7);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", int'({fl_sel_n, fl_rd_n, fl_wr_n}), 7);
    chk("R1 idle outputs", int'({fl_dq_oe, done, error}), 0);
    chk("R1 idle ready", int'(req_ready), 1);
    for (int e = 0; e < 2; e++)
      for (int t = 0; t < 2; t++)
        for (int b = 0; b < 6; b++)
          for (int r = 0; r < 2; r++)
            for (int f = 0; f < 2; f++)
              run_one(e[0], t[0], b, r[0], f[0], 1'b0);
    for (int e = 0; e < 2; e++)
      for (int t = 0; t < 2; t++)
        run_one(e[0], t[0], 0, 1'b0, 1'b0, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule